// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block gives each of a small, parameterised number of CPUs two inter-processor interrupt channels. The first, "other", is raised by any CPU on any set of CPUs through a bitmask write. The second, "self", is raised by a CPU on itself. Each CPU has a private write port. Through it the CPU sends, acknowledges, and sets or clears the masks of its own channels. Each CPU also has a 32-bit event word that reports its highest-priority live channel.

When a CPU consumes the reported event through its take strobe, the unit masks that channel automatically. The channel stays masked until software clears the mask. The pending state is untouched by a take and is removed only by an acknowledge. Software therefore usually acknowledges the channel, services it and then unmasks it. A request that arrives while the channel is masked is held and reported once the channel is unmasked.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every channel of every CPU is not pending and is masked, and every event word reads 0.
- R2: A send write (selector 0) with bit n set raises the "other" channel of CPU n. Bits 0 to NCPU-1 of the data are used as the target mask, and several targets may be hit by one write. Sends from several CPUs in the same cycle combine.
- R3: A send write with bit 31 set raises the "self" channel of the writing CPU only. It does not raise that CPU's "other" channel.
- R4: An acknowledge write (selector 1) clears the writing CPU's pending "other" channel for data bit 0 and its pending "self" channel for data bit 31.
- R5: A mask-set write (selector 2) masks, and a mask-clear write (selector 3) unmasks, the writing CPU's "other" channel (data bit 0) and "self" channel (data bit 31). Data bits that are 0 leave the mask unchanged.
- R6: The event word is 0x0004_0001 when "other" is pending and unmasked, 0x0004_0002 when "self" is the reported channel, and 0 when no channel is live. The upper half-word carries type 4 and the lower half-word carries the channel number.
- R7: When both channels are live, "other" is reported before "self".
- R8: A take strobe in a cycle with a nonzero event word masks the reported channel from the next cycle on. The channel stays pending, and the mask stays set until a mask-clear write. If a take and a mask-clear for that channel arrive in the same cycle, the channel ends up masked.
- R9: A send to a channel that is already pending merges with it, so one acknowledge leaves the channel idle.
- R10: A send that arrives in the same cycle as an acknowledge of the same channel leaves the channel pending.
- R11: A pending channel that is masked gives no event. It is reported as soon as its mask is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NCPU | Per-CPU write strobe |
| wr_sel | input | 2*NCPU | Per-CPU register selector (0 send, 1 ack, 2 mask-set, 3 mask-clear), 2 bits per CPU |
| wr_data | input | 32*NCPU | Per-CPU write data, 32 bits per CPU |
| ev_take | input | NCPU | Per-CPU event consume strobe |
| ev_word | output | 32*NCPU | Per-CPU event word, 32 bits per CPU |

## Verification
The stimulus covers the following cases:
- A multi-target send while the targets are masked, which separates holding a request from reporting it.
- Simultaneous "other" and "self" requests, which expose the priority order.
- Repeated takes, which show that the auto-mask hides a channel without clearing it.
- Two CPUs sending to one target in the same cycle, followed by a single acknowledge, which shows merging.
- A send that meets an acknowledge in the same cycle, which separates a lost request from a retained one.
- A take combined with a mask-clear in the same cycle.

A behavioural model recomputes every event word on every clock, so any divergence between directed checks is also caught.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int WORD_W    = 32;
    localparam int OTHER_BIT = 0;
    localparam int SELF_BIT  = 31;

    typedef enum logic [1:0] {
        SEL_SEND = 2'd0,
        SEL_ACK  = 2'd1,
        SEL_MSET = 2'd2,
        SEL_MCLR = 2'd3
    } ipi_sel_e;

    localparam logic [15:0] EV_TYPE_IPI  = 16'd4;
    localparam logic [15:0] EV_NUM_OTHER = 16'd1;
    localparam logic [15:0] EV_NUM_SELF  = 16'd2;

    // index 0: "other" channel, index 1: "self" channel
    typedef struct packed {
        logic [1:0] pend;
        logic [1:0] mask;
    } ipi_state_t;
endpackage

// File: rtl/ipi_send_gather.sv
module ipi_send_gather
    import ipi_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic [NCPU-1:0]        wr_en,
    input  logic [2*NCPU-1:0]      wr_sel,
    input  logic [WORD_W*NCPU-1:0] wr_data,
    output logic [NCPU-1:0]        other_hit
);
    // OR every CPU's send target mask into one hit vector per target
    always_comb begin
        other_hit = '0;
        for (int s = 0; s < NCPU; s++) begin
            if (wr_en[s] && ipi_sel_e'(wr_sel[2*s +: 2]) == SEL_SEND) begin
                other_hit |= wr_data[WORD_W*s +: NCPU];
            end
        end
    end
endmodule

// File: rtl/ipi_event_enc.sv
module ipi_event_enc
    import ipi_pkg::*;
(
    input  logic [1:0]        pend,
    input  logic [1:0]        mask,
    output logic [WORD_W-1:0] ev_word,
    output logic [1:0]        ev_chan
);
    logic [1:0] live;

    always_comb begin
        live    = pend & ~mask;
        ev_word = '0;
        ev_chan = 2'b00;
        if (live[0]) begin
            ev_word = {EV_TYPE_IPI, EV_NUM_OTHER};
            ev_chan = 2'b01;
        end else if (live[1]) begin
            ev_word = {EV_TYPE_IPI, EV_NUM_SELF};
            ev_chan = 2'b10;
        end
    end
endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              other_hit,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [1:0]        wr_bits,   // {data[31], data[0]}
    input  logic              ev_take,
    output logic [WORD_W-1:0] ev_word
);
    ipi_state_t st_q, st_d;
    logic [1:0] ev_chan;
    logic [1:0] ack_v, set_v, clr_v, take_v;
    logic       self_hit;

    ipi_event_enc u_enc (
        .pend    (st_q.pend),
        .mask    (st_q.mask),
        .ev_word (ev_word),
        .ev_chan (ev_chan)
    );

    always_comb begin
        self_hit = wr_en && ipi_sel_e'(wr_sel) == SEL_SEND && wr_bits[1];
        ack_v    = (wr_en && ipi_sel_e'(wr_sel) == SEL_ACK)  ? wr_bits : 2'b00;
        set_v    = (wr_en && ipi_sel_e'(wr_sel) == SEL_MSET) ? wr_bits : 2'b00;
        clr_v    = (wr_en && ipi_sel_e'(wr_sel) == SEL_MCLR) ? wr_bits : 2'b00;
        take_v   = ev_take ? ev_chan : 2'b00;

        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack_v) | {self_hit, other_hit};
        st_d.mask = (st_q.mask & ~clr_v) | set_v | take_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pend: 2'b00, mask: 2'b11};
        end else begin
            st_q <= st_d;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (st_q.pend == 2'b00 && st_q.mask == 2'b11));

    assert_other_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        other_hit |=> st_q.pend[0]);

    assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_v[0] && !other_hit) |=> !st_q.pend[0]);

    assert_take_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_take && ev_chan[0]) |=> st_q.mask[0]);

    assert_send_beats_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (other_hit && ack_v[0]) |=> st_q.pend[0]);

    assert_masked_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == 2'b11) |-> (ev_word == '0));
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCPU-1:0]        wr_en,
    input  logic [2*NCPU-1:0]      wr_sel,
    input  logic [WORD_W*NCPU-1:0] wr_data,
    input  logic [NCPU-1:0]        ev_take,
    output logic [WORD_W*NCPU-1:0] ev_word
);
    logic [NCPU-1:0] other_hit;
    logic            unused_data_bits;

    assign unused_data_bits = ^wr_data;

    ipi_send_gather #(.NCPU(NCPU)) u_gather (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .other_hit (other_hit)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        ipi_cpu_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .other_hit (other_hit[c]),
            .wr_en     (wr_en[c]),
            .wr_sel    (wr_sel[2*c +: 2]),
            .wr_bits   ({wr_data[WORD_W*c + SELF_BIT], wr_data[WORD_W*c + OTHER_BIT]}),
            .ev_take   (ev_take[c]),
            .ev_word   (ev_word[WORD_W*c +: WORD_W])
        );
    end
endmodule

// File: tb/ipi_unit_test.sv
`timescale 1ns/1ps
module ipi_unit_test;
    localparam int N = 4;
    localparam logic [31:0] EV_O = 32'h0004_0001;
    localparam logic [31:0] EV_S = 32'h0004_0002;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    wr_en = '0;
    logic [2*N-1:0]  wr_sel = '0;
    logic [32*N-1:0] wr_data = '0;
    logic [N-1:0]    ev_take = '0;
    logic [32*N-1:0] ev_word;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model state
    bit po[N], ps[N], mo[N], ms[N];

    ipi_unit #(.NCPU(N)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ev_take(ev_take), .ev_word(ev_word)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] model_ev(int c);
        if (po[c] && !mo[c]) return EV_O;
        if (ps[c] && !ms[c]) return EV_S;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        bit hit[N];
        logic [31:0] evm[N];
        if (!rst_n) begin
            for (int c = 0; c < N; c++) begin
                po[c] = 0; ps[c] = 0; mo[c] = 1; ms[c] = 1;
            end
        end else begin
            for (int t = 0; t < N; t++) begin
                hit[t] = 0;
                for (int s = 0; s < N; s++)
                    if (wr_en[s] && wr_sel[2*s +: 2] == 2'd0 && wr_data[32*s + t]) hit[t] = 1;
            end
            for (int c = 0; c < N; c++) evm[c] = model_ev(c);
            for (int c = 0; c < N; c++) begin
                logic [1:0]  sl;
                logic [31:0] d;
                bit en;
                en = wr_en[c]; sl = wr_sel[2*c +: 2]; d = wr_data[32*c +: 32];
                po[c] = (po[c] && !(en && sl == 2'd1 && d[0])) || hit[c];
                ps[c] = (ps[c] && !(en && sl == 2'd1 && d[31])) || (en && sl == 2'd0 && d[31]);
                mo[c] = (mo[c] && !(en && sl == 2'd3 && d[0])) || (en && sl == 2'd2 && d[0])
                        || (ev_take[c] && evm[c] == EV_O);
                ms[c] = (ms[c] && !(en && sl == 2'd3 && d[31])) || (en && sl == 2'd2 && d[31])
                        || (ev_take[c] && evm[c] == EV_S);
            end
        end
    end

    // continuous comparison against the model (event encoding, R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < N; c++) begin
                tests++;
                if (ev_word[32*c +: 32] !== model_ev(c)) begin
                    fails++;
                    $display("FAIL R6 model cpu%0d actual=%h expected=%h", c, ev_word[32*c +: 32], model_ev(c));
                end
            end
        end
    end

    task automatic chk(string tag, int c, logic [31:0] exp);
        tests++;
        if (ev_word[32*c +: 32] !== exp) begin
            fails++;
            $display("FAIL %s cpu%0d actual=%h expected=%h", tag, c, ev_word[32*c +: 32], exp);
        end
    endtask

    task automatic wr(int c, logic [1:0] sel, logic [31:0] d);
        wr_en[c] = 1'b1;
        wr_sel[2*c +: 2] = sel;
        wr_data[32*c +: 32] = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = '0; wr_sel = '0; wr_data = '0; ev_take = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < N; c++) chk("R1", c, 32'h0);

        // multi-target send while targets are masked
        wr(0, 2'd0, 32'h0000_0006); step();
        chk("R1", 1, 32'h0); chk("R11", 2, 32'h0);
        // unmask: held requests appear
        wr(1, 2'd3, 32'h8000_0001); wr(2, 2'd3, 32'h0000_0001); step();
        chk("R2", 1, EV_O); chk("R11", 2, EV_O); chk("R2", 0, 32'h0);
        // self on cpu1 while other live: priority
        wr(1, 2'd0, 32'h8000_0000); step();
        chk("R7", 1, EV_O); chk("R3", 0, 32'h0);
        // take masks other, self now reported
        ev_take[1] = 1'b1; step();
        chk("R8", 1, EV_S);
        ev_take[1] = 1'b1; step();
        chk("R8", 1, 32'h0);
        // pending retained: unmask other shows it again
        wr(1, 2'd3, 32'h0000_0001); step();
        chk("R8", 1, EV_O);
        wr(1, 2'd1, 32'h8000_0001); step();
        wr(1, 2'd3, 32'h8000_0001); step();
        chk("R4", 1, 32'h0);
        // merge: two senders hit cpu2 which is already pending
        wr(0, 2'd0, 32'h0000_0004); wr(3, 2'd0, 32'h0000_0004); step();
        chk("R9", 2, EV_O);
        wr(2, 2'd1, 32'h0000_0001); step();
        chk("R9", 2, 32'h0);
        // send meets ack in the same cycle
        wr(0, 2'd0, 32'h0000_0004); step();
        wr(2, 2'd1, 32'h0000_0001); wr(3, 2'd0, 32'h0000_0004); step();
        chk("R10", 2, EV_O);
        wr(2, 2'd1, 32'h0000_0001); step();
        chk("R4", 2, 32'h0);
        // mask-set / mask-clear on cpu3
        wr(3, 2'd3, 32'h0000_0001); wr(0, 2'd0, 32'h0000_0008); step();
        chk("R2", 3, EV_O);
        wr(3, 2'd2, 32'h0000_0001); step();
        chk("R5", 3, 32'h0);
        wr(3, 2'd3, 32'h0000_0001); step();
        chk("R5", 3, EV_O);
        // take and mask-clear in the same cycle: take wins
        ev_take[3] = 1'b1; wr(3, 2'd3, 32'h0000_0001); step();
        chk("R8", 3, 32'h0);
        // self raise on cpu3 only, while masked then unmasked
        wr(3, 2'd1, 32'h0000_0001); step();
        wr(3, 2'd0, 32'h8000_0000); step();
        chk("R3", 3, 32'h0); chk("R3", 0, 32'h0);
        wr(3, 2'd3, 32'h8000_0001); step();
        chk("R3", 3, EV_S); chk("R6", 0, 32'h0);
        wr(3, 2'd1, 32'h8000_0000); step();
        chk("R4", 3, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule